// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock level for an I2C controller. It runs from a single-cycle enable pulse that an external prescaler supplies, and it divides the rate of those pulses by 2 × (DIV + 3). DIV is an 8-bit divide field. Both halves of each period last DIV + 3 prescaler pulses, so the clock has a 50% duty cycle. The bit engine that drives SDA also needs to know when the clock changes. For this, the block asserts a one-cycle strobe in the same cycle that the clock level rises, and another in the same cycle that it falls.

The legal lower limit of DIV depends on the input digital filter. It is 3 when the filter is off and 6 when the filter is on. If the block runs with a DIV below the limit, it raises a sticky error flag and substitutes the minimum value. DIV is loaded only at half-period boundaries, or while the block is stopped, so a write during a transfer cannot produce a short pulse. While stopped, the clock rests high. After the run input is raised, the first edge is a falling edge one full half period later.

Top module: `i2c_sclk_div`

## Requirements
- R1: Out of reset, scl_o is 1, scl_rise_o and scl_fall_o are 0 and cfg_err_o is 0.
- R2: While running with a legal DIV, each half period of scl_o lasts exactly DIV + 3 cycles in which tick_i is 1. The high and low halves are equal, and cycles without tick_i do not advance the divider.
- R3: The first edge after run_i goes from 0 to 1 is a falling edge. It occurs on the (DIV + 3)-th tick_i cycle counted from the first rising clock edge at which run_i is seen high.
- R4: scl_fall_o is 1 for exactly the one cycle in which scl_o has just changed from 1 to 0. scl_rise_o is 1 for exactly the one cycle in which scl_o has just changed from 0 to 1. The two strobes are never 1 together, and each one appears only after a cycle in which tick_i was 1.
- R5: With filt_en_i = 0, a DIV below 3 is illegal, and the half period is 6 ticks (as if DIV were 3).
- R6: With filt_en_i = 1, a DIV below 6 is illegal, and the half period is 9 ticks (as if DIV were 6). A DIV of 6 or more is legal.
- R7: Running with an illegal DIV sets cfg_err_o one cycle later. The flag then stays 1 until rst_n is asserted, even after DIV becomes legal or run_i drops.
- R8: A change to DIV during a half period does not affect that half period. The new value applies from the next half period onward.
- R9: While run_i is 0, scl_o is 1 from the next cycle on, both strobes are 0, and tick_i has no effect.
- R10: div_i uses big-endian bit numbering. div_i[0] has weight 128 and div_i[7] has weight 1, so setting only div_i[4] and div_i[6] gives DIV = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable pulse from the prescaler |
| run_i | input | 1 | 1 = generate the clock; 0 = hold the clock high and reload the divider |
| filt_en_i | input | 1 | Input digital filter enabled (raises the minimum DIV) |
| div_i | input | 8 | Divide field, declared [0:7], bit 0 is the most significant bit |
| scl_o | output | 1 | Serial clock level |
| scl_rise_o | output | 1 | One-cycle strobe with the rising edge of scl_o |
| scl_fall_o | output | 1 | One-cycle strobe with the falling edge of scl_o |
| cfg_err_o | output | 1 | Sticky flag: the block ran with an illegal DIV |

## Verification
The assertions assume that tick_i is a clean synchronous pulse. They also assume that run_i, div_i and filt_en_i change only between clock edges and never as a glitch at an edge. The bench drives every input a fixed delay after the rising edge and samples a few nanoseconds later, so each value is stable across the edge that uses it. Tick spacing is chosen by the bench, either every cycle or every third cycle. The expected tick counts are therefore computed from the bench's own record of which cycles carried a tick.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = DIV_W + 1;
  localparam int HALF_OFS = 3;   // half period = DIV + HALF_OFS ticks
  localparam int MIN_RAW  = 3;   // minimum DIV, filter off
  localparam int MIN_FILT = 6;   // minimum DIV, filter on

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic div_t min_div(input logic filt);
    return filt ? div_t'(MIN_FILT) : div_t'(MIN_RAW);
  endfunction

  function automatic logic div_illegal(input div_t d, input logic filt);
    return d < min_div(filt);
  endfunction

  function automatic div_t eff_div(input div_t d, input logic filt);
    return div_illegal(d, filt) ? min_div(filt) : d;
  endfunction

  // counter starts at half-1 and fires on reaching zero
  function automatic cnt_t reload_of(input div_t d);
    return cnt_t'(d) + cnt_t'(HALF_OFS - 1);
  endfunction
endpackage

// File: rtl/sclk_cfg.sv
module sclk_cfg
  import sclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic filt_en,
  input  div_t div_raw,
  input  logic load,
  output div_t next_div,
  output div_t active_div,
  output logic div_low,
  output logic cfg_err
);
  assign div_low  = div_illegal(div_raw, filt_en);
  assign next_div = eff_div(div_raw, filt_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_div <= div_t'(MIN_RAW);
    end else if (!run || load) begin
      active_div <= next_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cfg_err <= 1'b0;
    else if (run && div_low) cfg_err <= 1'b1;
  end

  // R7
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R7
  cfg_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_low) |=> cfg_err);
  // R5
  eff_not_below_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_div >= div_t'(MIN_RAW));
endmodule

// File: rtl/sclk_halfcnt.sv
module sclk_halfcnt
  import sclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  div_t next_div,
  output cnt_t cnt,
  output logic half_done
);
  assign half_done = run && tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= reload_of(div_t'(MIN_RAW));
    end else if (!run || half_done) begin
      cnt <= reload_of(next_div);
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  cnt_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/sclk_level.sv
module sclk_level (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic half_done,
  output logic scl,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl  <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (!run) begin
      scl  <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (half_done) begin
      scl  <= ~scl;
      rise <= ~scl;
      fall <= scl;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
    end
  end

  // R4
  edges_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  // R4
  fall_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!scl && $past(scl)));
  // R4
  rise_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (scl && !$past(scl)));
  // R4
  edge_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |-> $past(tick));
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl && !rise && !fall));
endmodule

// File: rtl/i2c_sclk_div.sv
module i2c_sclk_div
  import sclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             filt_en_i,
  input  logic [0:DIV_W-1] div_i,
  output logic             scl_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o,
  output logic             cfg_err_o
);
  div_t div_val;
  div_t next_div, active_div;
  cnt_t cnt;
  logic half_done, div_low;

  // big-endian field: div_i[0] is the MSB
  for (genvar b = 0; b < DIV_W; b++) begin : g_bitrev
    assign div_val[DIV_W-1-b] = div_i[b];
  end

  sclk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run_i), .filt_en(filt_en_i),
    .div_raw(div_val), .load(half_done), .next_div(next_div),
    .active_div(active_div), .div_low(div_low), .cfg_err(cfg_err_o)
  );

  sclk_halfcnt u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_i), .tick(tick_i),
    .next_div(next_div), .cnt(cnt), .half_done(half_done)
  );

  sclk_level u_lvl (
    .clk(clk), .rst_n(rst_n), .run(run_i), .tick(tick_i),
    .half_done(half_done), .scl(scl_o), .rise(scl_rise_o), .fall(scl_fall_o)
  );

  // R8
  cnt_within_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt <= reload_of(active_div)));
  // R6
  filt_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && filt_en_i && !half_done) |=> (active_div >= div_t'(MIN_FILT)) || !$past(filt_en_i));
endmodule

// File: tb/i2c_sclk_div_bench.sv
`timescale 1ns/1ps
module i2c_sclk_div_bench;
  logic clk = 0, rst_n = 0, tick_i = 0, run_i = 0, filt_en_i = 0;
  logic [0:7] div_i = 8'd3;
  logic scl_o, scl_rise_o, scl_fall_o, cfg_err_o;
  int tests = 0, fails = 0;
  int gap = 1, ph = 0;

  always #10 clk = ~clk;

  i2c_sclk_div u_i2c_sclk_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .filt_en_i(filt_en_i), .div_i(div_i), .scl_o(scl_o),
    .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .cfg_err_o(cfg_err_o)
  );

  // prescaler model: a tick every 'gap' cycles, driven after the edge
  always @(posedge clk) begin
    #2;
    ph = (ph + 1 >= gap) ? 0 : ph + 1;
    tick_i = (ph == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for next strobe, counting tick cycles; check kind, count, level
  task automatic wait_edge(input bit exp_fall, input int exp_ticks, input string req);
    int n = 0;
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(posedge clk);
      if (tick_i) n++;
      #5;
      if (scl_rise_o || scl_fall_o) seen = 1;
    end
    chk(seen, {req, " edge seen"}, seen, 1);
    chk(scl_fall_o == exp_fall, {req, " edge kind (1=fall)"}, scl_fall_o, exp_fall);
    chk(scl_o == !exp_fall, {req, " level after edge"}, scl_o, !exp_fall);
    chk(n == exp_ticks, {req, " ticks in half period"}, n, exp_ticks);
  endtask

  task automatic start(input int d, input bit f);
    @(posedge clk); #2;
    run_i = 0; div_i = d[7:0]; filt_en_i = f;
    repeat (2) @(posedge clk);
    #2 run_i = 1;
  endtask

  task automatic do_reset;
    @(posedge clk); #2;
    run_i = 0; rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic t_reset;
    #5;
    chk(scl_o == 1, "R1 scl", scl_o, 1);
    chk(scl_rise_o == 0 && scl_fall_o == 0, "R1 strobes", scl_rise_o | scl_fall_o, 0);
    chk(cfg_err_o == 0, "R1 cfg_err", cfg_err_o, 0);
  endtask

  task automatic t_basic;
    gap = 1;
    start(3, 0);
    wait_edge(1, 6, "R3 first fall div3");
    wait_edge(0, 6, "R2 rise div3");
    wait_edge(1, 6, "R2 fall div3");
    chk(cfg_err_o == 0, "R5 div3 legal", cfg_err_o, 0);
  endtask

  task automatic t_sparse_ticks;
    gap = 3;
    start(10, 0);
    wait_edge(1, 13, "R2 sparse first fall");
    wait_edge(0, 13, "R2 sparse rise");
    gap = 1;
  endtask

  task automatic t_max;
    start(255, 0);
    wait_edge(1, 258, "R2 div255 fall");
    wait_edge(0, 258, "R2 div255 rise");
  endtask

  task automatic t_filter;
    start(6, 1);
    wait_edge(1, 9, "R6 div6 filt fall");
    wait_edge(0, 9, "R6 div6 filt rise");
    chk(cfg_err_o == 0, "R6 div6 legal", cfg_err_o, 0);
    start(4, 1);
    wait_edge(1, 9, "R6 div4 filt clamped");
    chk(cfg_err_o == 1, "R7 err after div4 filt", cfg_err_o, 1);
  endtask

  task automatic t_err_sticky;
    do_reset;
    #5 chk(cfg_err_o == 0, "R7 reset clears", cfg_err_o, 0);
    start(1, 0);
    wait_edge(1, 6, "R5 div1 clamped fall");
    wait_edge(0, 6, "R5 div1 clamped rise");
    chk(cfg_err_o == 1, "R7 err div1", cfg_err_o, 1);
    start(20, 0);
    repeat (5) @(posedge clk);
    #5 chk(cfg_err_o == 1, "R7 sticky after legal", cfg_err_o, 1);
    do_reset;
    #5 chk(cfg_err_o == 0, "R7 cleared by reset", cfg_err_o, 0);
  endtask

  task automatic t_midrun;
    start(3, 0);
    wait_edge(1, 6, "R8 fall before change");
    div_i = 8'd20;
    wait_edge(0, 6, "R8 current half unchanged");
    wait_edge(1, 23, "R8 new div low half");
    wait_edge(0, 23, "R8 new div high half");
  endtask

  task automatic t_disable;
    int bad = 0;
    start(5, 0);
    wait_edge(1, 8, "R3 fall before stop");
    @(posedge clk); #2 run_i = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #5;
      if (!scl_o || scl_rise_o || scl_fall_o) bad++;
    end
    chk(bad == 0, "R9 idle high, no strobes", bad, 0);
    #2 run_i = 1;
    wait_edge(1, 8, "R3 first fall after restart");
  endtask

  task automatic t_bitorder;
    @(posedge clk); #2;
    run_i = 0; filt_en_i = 0; div_i = '0;
    div_i[4] = 1'b1; div_i[6] = 1'b1;
    repeat (2) @(posedge clk);
    #2 run_i = 1;
    wait_edge(1, 13, "R10 big-endian div10");
    wait_edge(0, 13, "R10 big-endian div10 rise");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset;
    t_basic;
    t_sparse_ticks;
    t_filter;
    t_err_sticky;
    t_midrun;
    t_disable;
    t_bitorder;
    t_max;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule